// File: doc/BRIEF.md
# Serial Configuration Port with Burst Read

This block is the slave side of a three-wire serial management link. A host microcontroller uses it to reach the configuration and status registers of a four-channel Ethernet media interface. The wires are a serial clock, one bidirectional data line (split here into an input, an output and an output enable) and an active-low chip select. All three are oversampled in the block's own clock domain. A two-flop synchronizer feeds edge detection on the serial clock.

A frame opens with a 4-bit device address. A 1-bit direction flag follows (1 = read), then a 4-bit register number, then one data byte. Every field is sent most significant bit first. A frame whose device address differs from the strapped address is ignored. The strapped address is captured from the shared LED pins while a latch-enable is high during power-on reset, and it is held after that.

A read keeps going through the registers that follow for as long as chip select stays low. Register number 15 is not a real register. A read of it is steered to the lowest-numbered register that has a pending interrupt. The register file sits outside the block and is reached through a plain address, read-strobe, write-strobe and data interface.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset, `sdio_oe` is low and no `reg_rd` or `reg_wr` strobe occurs until a frame asks for one.
- R2: The device address follows `strap_pins` while `strap_en` is high. It is held unchanged while `strap_en` is low, whatever the pins do.
- R3: A frame is carried on nine header bits, each sampled at an SCLK rising edge, most significant bit first:
  - bits 8..5: device address
  - bit 4: direction flag (1 = read, 0 = write)
  - bits 3..0: register number
  
  The data byte follows, also most significant bit first.
- R4: A frame whose device address differs from the strapped address causes no strobe and never raises `sdio_oe`.
- R5: In a matching read, each data bit is presented on `sdio_out` after an SCLK falling edge, and `sdio_out` never changes while the synchronized SCLK is high. `sdio_oe` is low through the header and high through the data bits.
- R6: A matching write issues exactly one single-cycle `reg_wr` after the eighth data bit, with the byte on `reg_wdata`. Any further bits in the same frame are ignored.
- R7: While CS stays low, a read continues with the next register after every 8 data bits. The register number wraps from 14 to 0.
- R8: A read of register 15 starts at the lowest-numbered set bit of `irq_pend`, or at register 0 if no bit is set. `reg_rd` is never issued with address 15.
- R9: A write to register 15 is ignored: no `reg_wr` occurs.
- R10: Raising CS at any point aborts the frame. `sdio_oe` falls, and the next frame is decoded from its first header bit.
- R11: `reg_rd` is a single-cycle strobe, issued once for each register whose first data bit is put out. It is never issued together with `reg_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; SCLK half period must be at least 3 cycles of it |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_en | input | 1 | Reset-time enable that latches the device address from the LED pins |
| strap_pins | input | 4 | Shared LED pin levels read as the device address |
| sclk | input | 1 | Serial clock from the host, idle low |
| cs_n | input | 1 | Active-low chip select |
| sdio_in | input | 1 | Serial data from the host |
| sdio_out | output | 1 | Serial data to the host |
| sdio_oe | output | 1 | Output enable for the data line |
| irq_pend | input | 15 | One bit per register that holds a pending interrupt |
| reg_addr | output | 4 | Register file address |
| reg_rd | output | 1 | Read strobe; `reg_rdata` is captured in the same cycle |
| reg_wr | output | 1 | Write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rdata | input | 8 | Read data for `reg_addr` |

## Verification
The bench reads every register singly and writes every register. Each value is checked by a readback against a model that the bench computes, so a swapped field or a wrong bit order shows up as wrong bytes.

A burst that starts at register 12 exercises the 14-to-0 wrap. A design that counted through 15 would return a byte that nobody wrote.

Interrupt-steered reads are run with several pending patterns, including none pending and only the top register pending. This catches a wrong priority order, and it also catches any read of the unused address.

Frames carrying the LED value seen after reset must be ignored. That exposes an address latch that kept tracking the pins. Aborts placed in the header, the read data and the write data show whether a design leaks a write, keeps driving the line, or loses frame alignment.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;

  // Frame phases of the serial slave
  typedef enum logic [2:0] {
    PH_HDR   = 3'd0,  // shifting device address, direction, register number
    PH_WAITF = 3'd1,  // read: waiting for the falling edge that starts a byte
    PH_LOAD  = 3'd2,  // read: fetch register and present its MSB
    PH_RDATA = 3'd3,  // read: shifting data out
    PH_WDATA = 3'd4,  // write: shifting data in
    PH_SKIP  = 3'd5   // frame ignored until CS rises
  } phase_e;

endpackage

// File: rtl/cfg_serial_sync.sv
module cfg_serial_sync #(
  parameter int            W       = 3,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d;
      else stage_q[s] <= stage_q[(s > 0) ? s - 1 : 0];
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/cfg_serial_strap.sv
module cfg_serial_strap #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          latch_en,
  input  logic [AW-1:0] pins,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] addr_q, addr_d;

  always_comb begin
    addr_d = addr_q;
    if (latch_en) addr_d = pins;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else        addr_q <= addr_d;
  end

  assign addr = addr_q;

endmodule

// File: rtl/cfg_serial_irqsel.sv
module cfg_serial_irqsel #(
  parameter int RW   = 4,
  parameter int NREG = 15
) (
  input  logic [NREG-1:0] pend,
  output logic [RW-1:0]   sel
);

  // Lowest-numbered pending register wins; none pending selects 0.
  always_comb begin
    sel = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (pend[i]) sel = RW'(i);
    end
  end

endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_serial_pkg::*;
#(
  parameter int AW = 4,
  parameter int RW = 4,
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                strap_en,
  input  logic [AW-1:0]       strap_pins,
  input  logic                sclk,
  input  logic                cs_n,
  input  logic                sdio_in,
  output logic                sdio_out,
  output logic                sdio_oe,
  input  logic [(2**RW)-2:0]  irq_pend,
  output logic [RW-1:0]       reg_addr,
  output logic                reg_rd,
  output logic                reg_wr,
  output logic [DW-1:0]       reg_wdata,
  input  logic [DW-1:0]       reg_rdata
);

  localparam int            NREG  = (2**RW) - 1;
  localparam int            HW    = AW + 1 + RW;
  localparam int            CW    = $clog2(HW + 1);
  localparam logic [RW-1:0] REDIR = {RW{1'b1}};
  localparam logic [RW-1:0] LAST  = RW'(NREG - 1);

  // Synchronized pins: {cs_n, sclk, sdio_in}
  logic [2:0] pins_s;
  logic       sclk_s, sclk_q, cs_act, sdi_s, rise, fall;

  cfg_serial_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({cs_n, sclk, sdio_in}),
    .q     (pins_s)
  );

  assign cs_act = ~pins_s[2];
  assign sclk_s = pins_s[1];
  assign sdi_s  = pins_s[0];
  assign rise   = sclk_s & ~sclk_q;
  assign fall   = ~sclk_s & sclk_q;

  logic [AW-1:0] dev_addr;

  cfg_serial_strap #(.AW(AW)) i_strap (
    .clk      (clk),
    .rst_n    (rst_n),
    .latch_en (strap_en),
    .pins     (strap_pins),
    .addr     (dev_addr)
  );

  logic [RW-1:0] irq_sel;

  cfg_serial_irqsel #(.RW(RW), .NREG(NREG)) i_irqsel (
    .pend (irq_pend),
    .sel  (irq_sel)
  );

  // State
  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [HW-2:0] hdr_q, hdr_d;
  logic [HW-1:0] hdr_full;
  logic [RW-1:0] addr_q, addr_d;
  logic [DW-1:0] sh_q, sh_d;
  logic          sdo_q, sdo_d, oe_q, oe_d, wr_q, wr_d;

  // Next-state logic
  always_comb begin
    ph_d     = ph_q;
    cnt_d    = cnt_q;
    hdr_d    = hdr_q;
    addr_d   = addr_q;
    sh_d     = sh_q;
    sdo_d    = sdo_q;
    oe_d     = oe_q;
    wr_d     = 1'b0;
    hdr_full = {hdr_q, sdi_s};
    if (!cs_act) begin
      ph_d  = PH_HDR;
      cnt_d = '0;
      oe_d  = 1'b0;
    end else begin
      unique case (ph_q)
        PH_HDR: begin
          if (rise) begin
            hdr_d = hdr_full[HW-2:0];
            cnt_d = cnt_q + CW'(1);
            if (cnt_q == CW'(HW - 1)) begin
              cnt_d = '0;
              if (hdr_full[HW-1 -: AW] != dev_addr) begin
                ph_d = PH_SKIP;
              end else if (hdr_full[RW]) begin
                addr_d = (hdr_full[RW-1:0] == REDIR) ? irq_sel : hdr_full[RW-1:0];
                ph_d   = PH_WAITF;
              end else if (hdr_full[RW-1:0] == REDIR) begin
                ph_d = PH_SKIP;
              end else begin
                addr_d = hdr_full[RW-1:0];
                ph_d   = PH_WDATA;
              end
            end
          end
        end
        PH_WAITF: begin
          if (fall) ph_d = PH_LOAD;
        end
        PH_LOAD: begin
          sdo_d = reg_rdata[DW-1];
          sh_d  = {reg_rdata[DW-2:0], 1'b0};
          oe_d  = 1'b1;
          cnt_d = '0;
          ph_d  = PH_RDATA;
        end
        PH_RDATA: begin
          if (fall) begin
            sdo_d = sh_q[DW-1];
            sh_d  = {sh_q[DW-2:0], 1'b0};
          end else if (rise) begin
            cnt_d = cnt_q + CW'(1);
            if (cnt_q == CW'(DW - 1)) begin
              cnt_d  = '0;
              addr_d = (addr_q == LAST) ? '0 : addr_q + RW'(1);
              ph_d   = PH_WAITF;
            end
          end
        end
        PH_WDATA: begin
          if (rise) begin
            sh_d  = {sh_q[DW-2:0], sdi_s};
            cnt_d = cnt_q + CW'(1);
            if (cnt_q == CW'(DW - 1)) begin
              wr_d = 1'b1;
              ph_d = PH_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_HDR;
      cnt_q  <= '0;
      hdr_q  <= '0;
      addr_q <= '0;
      sh_q   <= '0;
      sdo_q  <= 1'b0;
      oe_q   <= 1'b0;
      wr_q   <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      hdr_q  <= hdr_d;
      addr_q <= addr_d;
      sh_q   <= sh_d;
      sdo_q  <= sdo_d;
      oe_q   <= oe_d;
      wr_q   <= wr_d;
      sclk_q <= sclk_s;
    end
  end

  assign sdio_out  = sdo_q;
  assign sdio_oe   = oe_q;
  assign reg_addr  = addr_q;
  assign reg_rd    = (ph_q == PH_LOAD) && cs_act;
  assign reg_wr    = wr_q;
  assign reg_wdata = sh_q;

endmodule

// File: rtl/cfg_serial_port_chk.sv
module cfg_serial_port_chk #(
  parameter int AW = 4,
  parameter int RW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_act,
  input logic          sclk_s,
  input logic          strap_en,
  input logic [AW-1:0] dev_addr,
  input logic          reg_rd,
  input logic          reg_wr,
  input logic [RW-1:0] reg_addr,
  input logic          sdio_out,
  input logic          sdio_oe
);

  assert_strap_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !strap_en |=> $stable(dev_addr));

  assert_out_stable_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_s |=> $stable(sdio_out));

  assert_single_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !reg_wr);

  assert_no_redir_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |-> (reg_addr != {RW{1'b1}}));

  assert_no_redir_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> (reg_addr != {RW{1'b1}}));

  assert_abort_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !sdio_oe);

  assert_rd_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !reg_rd);

  assert_rd_wr_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_rd && reg_wr));

endmodule

bind cfg_serial_port cfg_serial_port_chk #(.AW(AW), .RW(RW)) i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cs_act   (cs_act),
  .sclk_s   (sclk_s),
  .strap_en (strap_en),
  .dev_addr (dev_addr),
  .reg_rd   (reg_rd),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .sdio_out (sdio_out),
  .sdio_oe  (sdio_oe)
);

// File: tb/test_cfg_serial_port.sv
module test_cfg_serial_port;

  localparam int HALF = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strap_en = 1'b1;
  logic [3:0]  strap_pins = 4'hA;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdio_in = 1'b0;
  logic        sdio_out, sdio_oe;
  logic [14:0] irq_pend = '0;
  logic [3:0]  reg_addr;
  logic        reg_rd, reg_wr;
  logic [7:0]  reg_wdata, reg_rdata;

  always #10 clk = ~clk;  // 50 MHz

  cfg_serial_port i_cfg_serial_port (
    .clk(clk), .rst_n(rst_n), .strap_en(strap_en), .strap_pins(strap_pins),
    .sclk(sclk), .cs_n(cs_n), .sdio_in(sdio_in), .sdio_out(sdio_out),
    .sdio_oe(sdio_oe), .irq_pend(irq_pend), .reg_addr(reg_addr),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata)
  );

  // Register file of the environment
  logic [7:0] mem [15];
  int wr_cnt, rd_cnt;

  function automatic logic [7:0] init_val(input int i);
    return 8'((i * 29) + 7);
  endfunction

  assign reg_rdata = (reg_addr < 4'd15) ? mem[reg_addr] : 8'hEE;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 15; i++) mem[i] <= init_val(i);
      wr_cnt <= 0;
      rd_cnt <= 0;
    end else begin
      if (reg_wr && reg_addr < 4'd15) mem[reg_addr] <= reg_wdata;
      if (reg_wr) wr_cnt <= wr_cnt + 1;
      if (reg_rd) rd_cnt <= rd_cnt + 1;
    end
  end

  logic [7:0] exp_m [15];
  logic [7:0] rbuf [16];
  logic       hdr_oe, oe_all, oe_any;
  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic send_bit(input logic b);
    sdio_in = b;
    repeat (HALF) @(negedge clk);
    hdr_oe |= sdio_oe;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic send_hdr(input logic [3:0] dev, input logic rw, input logic [3:0] ra);
    logic [8:0] h;
    h = {dev, rw, ra};
    cs_n = 1'b0;
    hdr_oe = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 8; i >= 0; i--) send_bit(h[i]);
  endtask

  task automatic end_frame();
    sdio_in = 1'b0;
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic do_read(input logic [3:0] dev, input logic [3:0] ra, input int n);
    send_hdr(dev, 1'b1, ra);
    oe_all = 1'b1;
    oe_any = 1'b0;
    for (int b = 0; b < n; b++) begin
      for (int i = 7; i >= 0; i--) begin
        repeat (HALF) @(negedge clk);
        rbuf[b][i] = sdio_out;
        oe_all &= sdio_oe;
        oe_any |= sdio_oe;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        if (b == n - 1 && i == 0) begin
          cs_n = 1'b1;
          repeat (HALF) @(negedge clk);
        end
        sclk = 1'b0;
      end
    end
    end_frame();
  endtask

  task automatic do_write(input logic [3:0] dev, input logic [3:0] ra,
                          input logic [7:0] v, input bit extra);
    send_hdr(dev, 1'b0, ra);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    if (extra) for (int i = 0; i < 8; i++) send_bit(1'b1);
    end_frame();
  endtask

  initial begin
    int w0, r0;
    logic [7:0] v;
    for (int i = 0; i < 15; i++) exp_m[i] = init_val(i);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    strap_en = 1'b0;
    strap_pins = 4'h5;  // LED activity after the strap window
    repeat (4) @(negedge clk);

    // R1: reset state
    chk(sdio_oe == 1'b0, "R1 oe after reset", sdio_oe, 0);
    chk(wr_cnt == 0 && rd_cnt == 0, "R1 no strobes after reset", wr_cnt + rd_cnt, 0);

    // R3 R5 R11: single read of every register
    for (int a = 0; a < 15; a++) begin
      r0 = rd_cnt;
      do_read(4'hA, 4'(a), 1);
      chk(rbuf[0] == exp_m[a], $sformatf("R3 read reg %0d", a), rbuf[0], exp_m[a]);
      chk(oe_all && !hdr_oe, "R5 oe only in data phase", {hdr_oe, oe_all}, 1);
      chk(rd_cnt - r0 == 1, "R11 one read strobe", rd_cnt - r0, 1);
      chk(sdio_oe == 1'b0, "R10 oe released after CS", sdio_oe, 0);
    end

    // R6: write every register, then read back
    for (int a = 0; a < 15; a++) begin
      w0 = wr_cnt;
      v = 8'((a * 53 + 11) ^ 8'hA5);
      do_write(4'hA, 4'(a), v, a[0]);
      exp_m[a] = v;
      chk(wr_cnt - w0 == 1, "R6 one write strobe", wr_cnt - w0, 1);
    end
    for (int a = 0; a < 15; a++) begin
      do_read(4'hA, 4'(a), 1);
      chk(rbuf[0] == exp_m[a], $sformatf("R6 readback reg %0d", a), rbuf[0], exp_m[a]);
    end

    // R4 R2: frames addressed to the post-reset LED value are ignored
    r0 = rd_cnt;
    do_read(4'h5, 4'd2, 1);
    chk(!oe_any && rd_cnt == r0, "R4 R2 mismatched read ignored", {oe_any, 8'(rd_cnt - r0)}, 0);
    w0 = wr_cnt;
    do_write(4'h5, 4'd2, 8'h00, 1'b0);
    chk(wr_cnt == w0, "R4 mismatched write ignored", wr_cnt - w0, 0);
    do_read(4'hA, 4'd2, 1);
    chk(rbuf[0] == exp_m[2], "R4 reg 2 untouched", rbuf[0], exp_m[2]);

    // R7: burst with wrap 14 -> 0
    r0 = rd_cnt;
    do_read(4'hA, 4'd12, 5);
    for (int b = 0; b < 5; b++) begin
      chk(rbuf[b] == exp_m[(12 + b) % 15], $sformatf("R7 burst byte %0d", b),
          rbuf[b], exp_m[(12 + b) % 15]);
    end
    chk(rd_cnt - r0 == 5, "R11 burst strobes", rd_cnt - r0, 5);

    // R8: redirected reads
    irq_pend = 15'h0208;  // registers 3 and 9 pending
    do_read(4'hA, 4'hF, 2);
    chk(rbuf[0] == exp_m[3], "R8 lowest pending", rbuf[0], exp_m[3]);
    chk(rbuf[1] == exp_m[4], "R8 burst after redirect", rbuf[1], exp_m[4]);
    irq_pend = 15'h4000;  // only register 14
    do_read(4'hA, 4'hF, 2);
    chk(rbuf[0] == exp_m[14], "R8 top pending", rbuf[0], exp_m[14]);
    chk(rbuf[1] == exp_m[0], "R8 R7 wrap after redirect", rbuf[1], exp_m[0]);
    irq_pend = '0;
    do_read(4'hA, 4'hF, 1);
    chk(rbuf[0] == exp_m[0], "R8 none pending", rbuf[0], exp_m[0]);

    // R9: write to register 15 ignored
    w0 = wr_cnt;
    do_write(4'hA, 4'hF, 8'h3C, 1'b0);
    chk(wr_cnt == w0, "R9 write 15 ignored", wr_cnt - w0, 0);

    // R10: aborts in header, read data and write data
    cs_n = 1'b0;
    hdr_oe = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    end_frame();
    do_read(4'hA, 4'd6, 1);
    chk(rbuf[0] == exp_m[6], "R10 resync after header abort", rbuf[0], exp_m[6]);

    send_hdr(4'hA, 1'b1, 4'd7);
    for (int i = 0; i < 3; i++) send_bit(1'b0);
    end_frame();
    chk(sdio_oe == 1'b0, "R10 oe after read abort", sdio_oe, 0);
    do_read(4'hA, 4'd7, 1);
    chk(rbuf[0] == exp_m[7], "R10 read after read abort", rbuf[0], exp_m[7]);

    w0 = wr_cnt;
    send_hdr(4'hA, 1'b0, 4'd8);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    end_frame();
    chk(wr_cnt == w0, "R10 aborted write no strobe", wr_cnt - w0, 0);
    do_read(4'hA, 4'd8, 1);
    chk(rbuf[0] == exp_m[8], "R10 reg 8 kept", rbuf[0], exp_m[8]);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule